// File: doc/BRIEF.md
# Clock Manager Fault Recovery Controller

This block is a control state machine that brings a clock-management unit back into service after a monitor reports a fault. It also labels each fault by the recovery step that cleared it. While it waits, it watches a fault level from an external monitor. When a fault is reported, it runs a recovery sequence chosen by the operator. The sequence is built from two actions: a reset of the clock unit, and a request to an external engine to rewrite the unit's configuration memory.

In the escalating mode the controller resets the unit first. It then waits for lock and a short settle window, and samples the fault. If the fault is gone, the event is a data-path upset. If the fault is still there, the controller asks for a configuration rewrite and resets again. If the fault is gone after that, the event is a configuration upset. A fault that survives the last step is unrecoverable. The other modes run a fixed sequence: reset only, rewrite only, or rewrite followed by reset.

Lock is never taken as proof of health on its own. The fault input must also be clear. The lock input is not watched while a rewrite is in progress. Three saturating counters keep a tally of each outcome.

Top module: `clkrec_ctrl`

## Requirements
- R1: After reset, unit_rst_o, scrub_req_o, busy_o and all event outputs are 0 and all counters are 0; with fault_i low, none of them changes.
- R2: Every reset step drives unit_rst_o high for exactly RST_CYCLES consecutive cycles.
- R3: In escalating mode (mode_i = 2'b00), if the fault is clear after the first reset, lock and settle window, the controller pulses evt_valid_o with evt_datapath_o for one cycle, issues no rewrite request and increments cnt_datapath_o.
- R4: In escalating mode, if the fault persists after the first reset, scrub_req_o is held until scrub_done_i, a second reset follows, and a clear fault then gives an event with evt_config_o and increments cnt_config_o.
- R5: A fault still present after the last step of the selected sequence gives an event with evt_unrec_o and returns to the wait state. No new sequence starts until fault_i has been seen low.
- R6: In reset-only mode (mode_i = 2'b01) exactly one reset and no rewrite request are issued; the outcome is data-path or unrecoverable.
- R7: In rewrite-only mode (mode_i = 2'b10) exactly one rewrite request and no reset are issued; a clear fault after it is classified as configuration.
- R8: In rewrite-then-reset mode (mode_i = 2'b11) one rewrite request is followed by one reset; a clear fault is classified as configuration.
- R9: A step fails if locked_i does not rise within LOCK_TMO_SHORT cycles after the reset ends (LOCK_TMO_LONG when slow_lock_i is 1).
- R10: A step passes only if locked_i is high and fault_i is low at the end of the settle window; lock with a standing fault counts as failure, and a lock drop during a rewrite has no effect.
- R11: Each counter increments by one per event of its class and holds at its maximum value.
- R12: mode_i is sampled when the fault is accepted; later changes to it do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Correction mode: 00 escalate, 01 reset only, 10 rewrite only, 11 rewrite then reset |
| slow_lock_i | input | 1 | Selects the long lock timeout (frequency synthesis use) |
| fault_i | input | 1 | Fault level from the output monitor |
| locked_i | input | 1 | Lock indication from the clock unit |
| scrub_done_i | input | 1 | Configuration rewrite completed |
| unit_rst_o | output | 1 | Reset to the clock unit |
| scrub_req_o | output | 1 | Configuration rewrite request, held until done |
| busy_o | output | 1 | A recovery sequence is running |
| evt_valid_o | output | 1 | One-cycle pulse: a sequence finished |
| evt_datapath_o | output | 1 | Event class: cleared by reset alone |
| evt_config_o | output | 1 | Event class: cleared after a rewrite |
| evt_unrec_o | output | 1 | Event class: not cleared |
| cnt_datapath_o | output | CNT_W | Saturating count of data-path events |
| cnt_config_o | output | CNT_W | Saturating count of configuration events |
| cnt_unrec_o | output | CNT_W | Saturating count of unrecoverable events |

## Verification
The bench covers every mode against every fault kind. A fault kind is one the model clears on reset, one it clears on rewrite, or one it never clears. This grid separates the modes by which step can clear which kind, and it checks the class label, the number of reset pulses and the number of rewrite requests. A lock delay longer than the short timeout is tried with and without the long timeout, which tells a timed-out lock from a late but valid one. A mode change in mid-sequence, a lock drop during every rewrite, and the counter tallies running past their limit cover sampling, lock handling and saturation.

// File: rtl/clkrec_pkg.sv
package clkrec_pkg;

  typedef enum logic [1:0] {
    MODE_ESCALATE   = 2'b00,
    MODE_RST_ONLY   = 2'b01,
    MODE_SCRUB_ONLY = 2'b10,
    MODE_SCRUB_RST  = 2'b11
  } rec_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_LOCK,
    ST_SETTLE,
    ST_SCRUB
  } rec_state_e;

  localparam int unsigned NUM_CLASS = 3;
  localparam int unsigned CLS_DP    = 0;
  localparam int unsigned CLS_CF    = 1;
  localparam int unsigned CLS_UR    = 2;

endpackage

// File: rtl/clkrec_timer.sv
module clkrec_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/clkrec_sat_cnt.sv
module clkrec_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (inc_i && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/clkrec_fsm.sv
module clkrec_fsm
  import clkrec_pkg::*;
#(
  parameter int unsigned RST_CYCLES     = 8,
  parameter int unsigned SETTLE_CYCLES  = 16,
  parameter int unsigned LOCK_TMO_SHORT = 16000,
  parameter int unsigned LOCK_TMO_LONG  = 1250000,
  parameter int unsigned TMR_W          = 21
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic                 slow_lock_i,
  input  logic                 fault_i,
  input  logic                 locked_i,
  input  logic                 scrub_done_i,
  input  logic                 tmr_exp_i,
  output logic                 tmr_load_o,
  output logic [TMR_W-1:0]     tmr_val_o,
  output logic                 unit_rst_o,
  output logic                 scrub_req_o,
  output logic                 busy_o,
  output logic                 evt_valid_o,
  output logic                 evt_datapath_o,
  output logic                 evt_config_o,
  output logic                 evt_unrec_o,
  output logic [NUM_CLASS-1:0] inc_o
);

  localparam logic [TMR_W-1:0] RST_LD    = TMR_W'(RST_CYCLES - 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYCLES - 1);
  localparam logic [TMR_W-1:0] TMO_S_LD  = TMR_W'(LOCK_TMO_SHORT - 1);
  localparam logic [TMR_W-1:0] TMO_L_LD  = TMR_W'(LOCK_TMO_LONG - 1);

  rec_state_e state_q, state_d;
  rec_mode_e  mode_q, mode_d;
  logic       scrubbed_q, scrubbed_d;
  logic       armed_q, armed_d;
  logic       step_pass, step_fail;
  logic       dp_inc, cf_inc, ur_inc;

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    scrubbed_d = scrubbed_q;
    armed_d    = armed_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    step_pass  = 1'b0;
    step_fail  = 1'b0;
    dp_inc     = 1'b0;
    cf_inc     = 1'b0;
    ur_inc     = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (!fault_i) armed_d = 1'b1;
        if (fault_i && armed_q) begin
          mode_d     = rec_mode_e'(mode_i);
          scrubbed_d = 1'b0;
          // bit 1 of the mode selects a rewrite as the first step
          if (mode_i[1]) begin
            state_d = ST_SCRUB;
          end else begin
            state_d    = ST_RST;
            tmr_load_o = 1'b1;
            tmr_val_o  = RST_LD;
          end
        end
      end
      ST_RST: begin
        if (tmr_exp_i) begin
          state_d    = ST_LOCK;
          tmr_load_o = 1'b1;
          tmr_val_o  = slow_lock_i ? TMO_L_LD : TMO_S_LD;
        end
      end
      ST_LOCK: begin
        if (locked_i) begin
          state_d    = ST_SETTLE;
          tmr_load_o = 1'b1;
          tmr_val_o  = SETTLE_LD;
        end else if (tmr_exp_i) begin
          step_fail = 1'b1;
        end
      end
      ST_SETTLE: begin
        // lock alone is not trusted: the monitor must also report clean
        if (tmr_exp_i) begin
          if (locked_i && !fault_i) step_pass = 1'b1;
          else                      step_fail = 1'b1;
        end
      end
      ST_SCRUB: begin
        // lock is not watched while the rewrite runs
        if (scrub_done_i) begin
          scrubbed_d = 1'b1;
          tmr_load_o = 1'b1;
          if (mode_q == MODE_SCRUB_ONLY) begin
            state_d   = ST_SETTLE;
            tmr_val_o = SETTLE_LD;
          end else begin
            state_d   = ST_RST;
            tmr_val_o = RST_LD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (step_pass) begin
      state_d = ST_IDLE;
      if (scrubbed_q) cf_inc = 1'b1;
      else            dp_inc = 1'b1;
    end

    if (step_fail) begin
      if (mode_q == MODE_ESCALATE && !scrubbed_q) begin
        state_d = ST_SCRUB;
      end else begin
        state_d = ST_IDLE;
        ur_inc  = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      mode_q         <= MODE_ESCALATE;
      scrubbed_q     <= 1'b0;
      armed_q        <= 1'b1;
      evt_valid_o    <= 1'b0;
      evt_datapath_o <= 1'b0;
      evt_config_o   <= 1'b0;
      evt_unrec_o    <= 1'b0;
    end else begin
      state_q        <= state_d;
      mode_q         <= mode_d;
      scrubbed_q     <= scrubbed_d;
      armed_q        <= armed_d;
      evt_valid_o    <= dp_inc | cf_inc | ur_inc;
      evt_datapath_o <= dp_inc;
      evt_config_o   <= cf_inc;
      evt_unrec_o    <= ur_inc;
    end
  end

  assign unit_rst_o          = (state_q == ST_RST);
  assign scrub_req_o         = (state_q == ST_SCRUB);
  assign busy_o              = (state_q != ST_IDLE);
  assign inc_o[CLS_DP]       = dp_inc;
  assign inc_o[CLS_CF]       = cf_inc;
  assign inc_o[CLS_UR]       = ur_inc;

endmodule

// File: rtl/clkrec_ctrl.sv
module clkrec_ctrl
  import clkrec_pkg::*;
#(
  parameter int unsigned RST_CYCLES     = 8,
  parameter int unsigned SETTLE_CYCLES  = 16,
  parameter int unsigned LOCK_TMO_SHORT = 16000,
  parameter int unsigned LOCK_TMO_LONG  = 1250000,
  parameter int unsigned CNT_W          = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             slow_lock_i,
  input  logic             fault_i,
  input  logic             locked_i,
  input  logic             scrub_done_i,
  output logic             unit_rst_o,
  output logic             scrub_req_o,
  output logic             busy_o,
  output logic             evt_valid_o,
  output logic             evt_datapath_o,
  output logic             evt_config_o,
  output logic             evt_unrec_o,
  output logic [CNT_W-1:0] cnt_datapath_o,
  output logic [CNT_W-1:0] cnt_config_o,
  output logic [CNT_W-1:0] cnt_unrec_o
);

  localparam int unsigned TMO_MAX = (LOCK_TMO_LONG > LOCK_TMO_SHORT) ? LOCK_TMO_LONG : LOCK_TMO_SHORT;
  localparam int unsigned LOC_MAX = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
  localparam int unsigned TMR_MAX = (TMO_MAX > LOC_MAX) ? TMO_MAX : LOC_MAX;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

  logic                 tmr_load, tmr_exp;
  logic [TMR_W-1:0]     tmr_val;
  logic [NUM_CLASS-1:0] inc;
  logic [CNT_W-1:0]     cnt [NUM_CLASS];

  clkrec_fsm #(
    .RST_CYCLES    (RST_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .LOCK_TMO_SHORT(LOCK_TMO_SHORT),
    .LOCK_TMO_LONG (LOCK_TMO_LONG),
    .TMR_W         (TMR_W)
  ) fsm_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_i),
    .slow_lock_i   (slow_lock_i),
    .fault_i       (fault_i),
    .locked_i      (locked_i),
    .scrub_done_i  (scrub_done_i),
    .tmr_exp_i     (tmr_exp),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .unit_rst_o    (unit_rst_o),
    .scrub_req_o   (scrub_req_o),
    .busy_o        (busy_o),
    .evt_valid_o   (evt_valid_o),
    .evt_datapath_o(evt_datapath_o),
    .evt_config_o  (evt_config_o),
    .evt_unrec_o   (evt_unrec_o),
    .inc_o         (inc)
  );

  clkrec_timer #(.W(TMR_W)) tmr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expired_o(tmr_exp)
  );

  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cnt
    clkrec_sat_cnt #(.W(CNT_W)) cnt_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (inc[g]),
      .cnt_o (cnt[g])
    );
  end

  assign cnt_datapath_o = cnt[CLS_DP];
  assign cnt_config_o   = cnt[CLS_CF];
  assign cnt_unrec_o    = cnt[CLS_UR];

endmodule

// File: rtl/clkrec_checker.sv
module clkrec_checker #(
  parameter int unsigned RST_CYCLES = 8,
  parameter int unsigned CNT_W      = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scrub_done_i,
  input logic             unit_rst_o,
  input logic             scrub_req_o,
  input logic             busy_o,
  input logic             evt_valid_o,
  input logic             evt_datapath_o,
  input logic             evt_config_o,
  input logic             evt_unrec_o,
  input logic [CNT_W-1:0] cnt_datapath_o,
  input logic [CNT_W-1:0] cnt_config_o,
  input logic [CNT_W-1:0] cnt_unrec_o
);

  localparam int unsigned RW = $clog2(RST_CYCLES + 2) + 1;
  logic [RW-1:0] rst_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rst_run <= '0;
    else if (!unit_rst_o)              rst_run <= '0;
    else if (rst_run != '1)            rst_run <= rst_run + 1'b1;
  end

  AST_RST_HOLD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unit_rst_o && rst_run != '0) |-> (rst_run == RW'(RST_CYCLES))); // R2

  AST_CLASS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o == $onehot({evt_datapath_o, evt_config_o, evt_unrec_o})); // R3

  AST_SCRUB_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scrub_req_o && !scrub_done_i) |=> scrub_req_o); // R4

  AST_EVT_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> !busy_o); // R5

  AST_DP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_datapath_o == '1) |=> (cnt_datapath_o == '1)); // R11

  AST_CF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_config_o != $past(cnt_config_o)) |->
      (evt_config_o && cnt_config_o == CNT_W'($past(cnt_config_o) + 1'b1))); // R11

  AST_UR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_unrec_o != $past(cnt_unrec_o)) |->
      (evt_unrec_o && cnt_unrec_o == CNT_W'($past(cnt_unrec_o) + 1'b1))); // R11

endmodule

bind clkrec_ctrl clkrec_checker #(
  .RST_CYCLES(RST_CYCLES),
  .CNT_W     (CNT_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .scrub_done_i  (scrub_done_i),
  .unit_rst_o    (unit_rst_o),
  .scrub_req_o   (scrub_req_o),
  .busy_o        (busy_o),
  .evt_valid_o   (evt_valid_o),
  .evt_datapath_o(evt_datapath_o),
  .evt_config_o  (evt_config_o),
  .evt_unrec_o   (evt_unrec_o),
  .cnt_datapath_o(cnt_datapath_o),
  .cnt_config_o  (cnt_config_o),
  .cnt_unrec_o   (cnt_unrec_o)
);

// File: tb/clkrec_ctrl_tb_top.sv
module clkrec_ctrl_tb_top;

  localparam int RST_C  = 3;
  localparam int SET_C  = 4;
  localparam int TMO_S  = 20;
  localparam int TMO_L  = 200;
  localparam int CW     = 2;
  localparam int CMAX   = (1 << CW) - 1;
  localparam int K_DP   = 0, K_CF = 1, K_PERM = 2;
  localparam int C_NONE = 0, C_DP = 1, C_CF = 2, C_UR = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          slow_lock_i = 1'b0;
  logic          fault_i = 1'b0;
  logic          locked_i = 1'b1;
  logic          scrub_done_i = 1'b0;
  logic          unit_rst_o, scrub_req_o, busy_o;
  logic          evt_valid_o, evt_datapath_o, evt_config_o, evt_unrec_o;
  logic [CW-1:0] cnt_datapath_o, cnt_config_o, cnt_unrec_o;

  always #4 clk_i = ~clk_i;

  clkrec_ctrl #(
    .RST_CYCLES(RST_C), .SETTLE_CYCLES(SET_C),
    .LOCK_TMO_SHORT(TMO_S), .LOCK_TMO_LONG(TMO_L), .CNT_W(CW)
  ) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int n_rst, n_scr, n_evt, got_cls;
  int rst_len = 0;
  bit rst_prev = 0, scr_prev = 0;
  int kind_q = K_DP, lock_dly = 6, lock_cnt = 0, sc_cnt = 0;
  int e_dp = 0, e_cf = 0, e_ur = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // one cycle: monitors then a model of the clock unit and rewrite engine
  task automatic tick();
    @(negedge clk_i);
    if (unit_rst_o) begin
      if (!rst_prev) n_rst++;
      rst_len++;
    end else if (rst_prev) begin
      chk(rst_len == RST_C, "R2 reset width", rst_len, RST_C);
      rst_len = 0;
    end
    rst_prev = unit_rst_o;
    if (scrub_req_o && !scr_prev) n_scr++;
    scr_prev = scrub_req_o;
    if (evt_valid_o) begin
      n_evt++;
      got_cls = evt_datapath_o ? C_DP : evt_config_o ? C_CF : evt_unrec_o ? C_UR : C_NONE;
    end
    if (unit_rst_o) begin
      locked_i = 1'b0;
      lock_cnt = 0;
      if (kind_q == K_DP) fault_i = 1'b0;
    end else if (scrub_req_o && !scrub_done_i) begin
      locked_i = 1'b0;  // lock disturbance during rewrite, R10
      sc_cnt++;
      if (sc_cnt == 5) begin
        scrub_done_i = 1'b1;
        locked_i = 1'b1;
        if (kind_q == K_CF) fault_i = 1'b0;
      end
    end else begin
      scrub_done_i = 1'b0;
      sc_cnt = 0;
      if (!locked_i) begin
        lock_cnt++;
        if (lock_cnt >= lock_dly) locked_i = 1'b1;
      end
    end
  endtask

  function automatic int exp_cls(input int mode, input int kind, input bit lok);
    case (mode)
      0:       return (kind == K_DP && lok) ? C_DP : (kind != K_PERM && lok) ? C_CF : C_UR;
      1:       return (kind == K_DP && lok) ? C_DP : C_UR;
      2:       return (kind == K_CF) ? C_CF : C_UR;
      default: return (kind != K_PERM && lok) ? C_CF : C_UR;
    endcase
  endfunction

  task automatic run_case(input int mode, input int kind, input int ldly,
                          input bit slow, input bit chg_mode);
    int cls, x_rst, x_scr, i0, i1, i2;
    bit lok;
    lock_dly = ldly;
    slow_lock_i = slow;
    mode_i = 2'(mode);
    kind_q = kind;
    while (!locked_i) tick();
    tick();
    n_rst = 0; n_scr = 0; n_evt = 0; got_cls = C_NONE;
    lok = (ldly < (slow ? TMO_L : TMO_S));
    cls = exp_cls(mode, kind, lok);
    case (mode)
      0:       begin x_rst = (cls == C_DP) ? 1 : 2; x_scr = (cls == C_DP) ? 0 : 1; end
      1:       begin x_rst = 1; x_scr = 0; end
      2:       begin x_rst = 0; x_scr = 1; end
      default: begin x_rst = 1; x_scr = 1; end
    endcase
    fault_i = 1'b1;
    for (int i = 0; i < 3000 && n_evt == 0; i++) begin
      if (chg_mode && i == 2) mode_i = 2'b01;  // R12 change after acceptance
      tick();
    end
    chk(got_cls == cls, chg_mode ? "R12 class" : "R3/R4/R6/R7/R8 class", got_cls, cls);
    chk(n_rst == x_rst, "R6/R7/R8 reset steps", n_rst, x_rst);
    chk(n_scr == x_scr, "R4/R7/R8 rewrite requests", n_scr, x_scr);
    if (cls == C_DP) e_dp++;
    if (cls == C_CF) e_cf++;
    if (cls == C_UR) e_ur++;
    chk(int'(cnt_datapath_o) == sat(e_dp), "R11 dp count", cnt_datapath_o, sat(e_dp));
    chk(int'(cnt_config_o) == sat(e_cf), "R11 cf count", cnt_config_o, sat(e_cf));
    chk(int'(cnt_unrec_o) == sat(e_ur), "R11 ur count", cnt_unrec_o, sat(e_ur));
    if (cls == C_UR) begin
      i0 = n_rst; i1 = n_scr; i2 = n_evt;
      repeat (30) tick();
      chk(n_rst == i0 && n_scr == i1 && n_evt == i2 && !busy_o,
          "R5 no restart while fault held", n_rst + n_scr + n_evt, i0 + i1 + i2);
      fault_i = 1'b0;
    end
    repeat (3) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (10) begin
      tick();
      chk(!unit_rst_o && !scrub_req_o && !busy_o && !evt_valid_o
          && cnt_datapath_o == 0 && cnt_config_o == 0 && cnt_unrec_o == 0,
          "R1 quiet after reset", {unit_rst_o, scrub_req_o, busy_o, evt_valid_o}, 0);
    end
    // full grid: every mode against every fault kind, lock within timeout
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 3; k++)
        run_case(m, k, 6, 1'b0, 1'b0);
    // R9: late lock fails the step on the short window, passes on the long one
    run_case(1, K_DP, 100, 1'b0, 1'b0);
    run_case(1, K_DP, 100, 1'b1, 1'b0);
    run_case(0, K_DP, 100, 1'b0, 1'b0);
    // R10: lock regained but fault standing stays unrecoverable
    run_case(3, K_PERM, 2, 1'b0, 1'b0);
    // R12: mode change after the fault is accepted
    run_case(0, K_CF, 6, 1'b0, 1'b1);
    // R11: saturated counters hold at the limit
    chk(int'(cnt_unrec_o) == CMAX, "R11 unrec saturated", cnt_unrec_o, CMAX);
    chk(int'(cnt_config_o) == CMAX, "R11 config saturated", cnt_config_o, CMAX);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule